// File: doc/BRIEF.md
# Gamma Curve Table Write Port

This block sits between a register write bus and the RAMs of a three-segment gamma curve. Software first writes an index register to pick a start pointer and, optionally, auto-increment. It then streams 32-bit data words. Every curve entry holds three 16-bit channel values in 12.4 fixed point. Each entry is sent as two words: the first carries the upper ten bits of each channel and the second carries the lower six. The block keeps the first word, joins it with the second, and issues one table write strobe. The strobe carries a segment code, a slot number and the three assembled channel values. The RAMs beside the block decode that strobe.

The main data port runs one pointer through 512 positions. The first half fills the fine segment and the second half fills the coarse segment. A second index/data pair, with its own pointer and its own half-word phase, fills the nine-entry superfine segment. Three more registers hold the red, green and blue end-point values of the curve. These go straight to outputs.

Top module: `gamma_lut_port`

## Requirements
- R1: While reset (rstN low) is held, and after it is released, lutWrEn is 0, lutSeg, lutSlot and the three lut colour outputs are 0, and maxRed, maxGreen and maxBlue are 0.
- R2: Register select wrAddr decodes as 0 main index, 1 main data, 2 superfine index, 3 superfine data, 4 red end point, 5 green end point, 6 blue end point. In the first data word of a pair, red bits [15:6] sit at [29:20], green [15:6] at [19:10] and blue [15:6] at [9:0].
- R3: In the second data word of a pair, red bits [5:0] sit at [29:24], green [5:0] at [19:14] and blue [5:0] at [9:4].
- R4: Only the second data word of a pair produces a write. lutWrEn is high for exactly the one cycle after the clock edge that takes that word. The segment, slot and colour outputs keep their values until the next write.
- R5: A write to an index register makes the next data word on that port be taken as a first word. Any first word already held is discarded.
- R6: The index word has its start pointer in the low bits ([8:0] main, [3:0] superfine) and an auto-increment flag at bit 15. With the flag set, the pointer steps by one after each complete pair. With the flag clear, the pointer stays put.
- R7: Segment codes are 0 superfine, 1 fine, 2 coarse. Main pointer p in 0..255 writes fine slot p+1, so fine slot 0 is never written. Pointer p in 256..511 writes coarse slot p-256. The pointer wraps from 511 to 0.
- R8: The superfine port writes segment 0 at slot equal to its pointer (0..8). A pair taken while that pointer is above 8 writes nothing, and the pointer then stops advancing.
- R9: The main and superfine ports keep separate phases and held first words. Interleaving their data words assembles each entry only from its own port's words.
- R10: A write to an end-point register loads wrData[15:0] into that channel's max output on the next clock edge. The other channels are unaffected.
- R11: A write with wrAddr 7 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Register write data |
| lutWrEn | output | 1 | Table write strobe, one cycle per entry |
| lutSeg | output | 2 | Target segment: 0 superfine, 1 fine, 2 coarse |
| lutSlot | output | 9 | Slot within the target segment |
| lutRed | output | 16 | Assembled red value |
| lutGreen | output | 16 | Assembled green value |
| lutBlue | output | 16 | Assembled blue value |
| maxRed | output | 16 | Red end point |
| maxGreen | output | 16 | Green end point |
| maxBlue | output | 16 | Blue end point |

## Verification
A table write shows up on lutWrEn exactly one cycle after the edge that takes the second word of a pair. An end-point register changes on the same edge that takes its write. The bench drives on falling edges. Each entry it sends into the scoreboard queue is stamped with the cycle number in which the write is due. The monitor samples on the following falling edge and fails any entry that arrives in another cycle, in another order, or with no entry expected. Register and reset results are compared one time unit after the rising edge that loads them. Dropped pairs are shown by an empty queue once the stimulus has settled.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // data word geometry
  localparam int CH_W     = 16;
  localparam int HI_W     = 10;
  localparam int LO_W     = CH_W - HI_W;
  localparam int R_HI_LSB = 20;
  localparam int G_HI_LSB = 10;
  localparam int B_HI_LSB = 0;
  localparam int R_LO_LSB = 24;
  localparam int G_LO_LSB = 14;
  localparam int B_LO_LSB = 4;
  localparam int USED_W   = R_LO_LSB + LO_W;
  localparam int AUTO_BIT = 15;
  localparam int SLOT_W   = 9;
  localparam int ADDR_W   = 3;
  localparam int N_CH     = 3;
  localparam int N_PORT   = 2;

  localparam logic [ADDR_W-1:0] REG_MAIN_IDX  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MAIN_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] REG_SF_IDX    = 3'd2;
  localparam logic [ADDR_W-1:0] REG_SF_DATA   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_MAX_R     = 3'd4;
  localparam logic [ADDR_W-1:0] REG_MAX_G     = 3'd5;
  localparam logic [ADDR_W-1:0] REG_MAX_B     = 3'd6;

  typedef enum logic [1:0] {
    SEG_SUPERFINE = 2'd0,
    SEG_FINE      = 2'd1,
    SEG_COARSE    = 2'd2
  } seg_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [N_PORT-1:0] holdLoad;   // capture first word, per port
    logic              commit;     // second word: emit entry
    logic              commitSrc;  // 0 main port, 1 superfine port
    seg_e              seg;
    logic [SLOT_W-1:0] slot;
    logic [N_CH-1:0]   maxLoad;    // red, green, blue
  } strobe_t;

endpackage

// File: rtl/gamma_port_ctrl.sv
module gamma_port_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int FINE_N   = 256,
  parameter int COARSE_N = 256,
  parameter int SF_N     = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [$clog2(FINE_N+COARSE_N)-1:0] idxMain,
  input  logic [$clog2(SF_N+1)-1:0]     idxSf,
  input  logic                          idxAuto,
  output strobe_t                       strobe
);

  localparam int MAIN_N = FINE_N + COARSE_N;
  localparam int MAIN_W = $clog2(MAIN_N);
  localparam int SF_W   = $clog2(SF_N + 1);

  logic [MAIN_W-1:0] mainPtr;
  logic              mainAuto;
  logic              mainOdd;
  logic [SF_W-1:0]   sfPtr;
  logic              sfAuto;
  logic              sfOdd;

  logic isMainData, isSfData, sfInRange;

  assign isMainData = wrEn && (wrAddr == REG_MAIN_DATA);
  assign isSfData   = wrEn && (wrAddr == REG_SF_DATA);
  assign sfInRange  = sfPtr < SF_W'(SF_N);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainPtr  <= '0;
      mainAuto <= 1'b0;
      mainOdd  <= 1'b0;
      sfPtr    <= '0;
      sfAuto   <= 1'b0;
      sfOdd    <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_MAIN_IDX: begin
          mainPtr  <= idxMain;
          mainAuto <= idxAuto;
          mainOdd  <= 1'b0;
        end
        REG_MAIN_DATA: begin
          mainOdd <= !mainOdd;
          if (mainOdd && mainAuto)
            mainPtr <= (mainPtr == MAIN_W'(MAIN_N - 1)) ? '0 : mainPtr + MAIN_W'(1);
        end
        REG_SF_IDX: begin
          sfPtr  <= idxSf;
          sfAuto <= idxAuto;
          sfOdd  <= 1'b0;
        end
        REG_SF_DATA: begin
          sfOdd <= !sfOdd;
          if (sfOdd && sfAuto && sfInRange)
            sfPtr <= sfPtr + SF_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.holdLoad[0] = isMainData && !mainOdd;
    strobe.holdLoad[1] = isSfData && !sfOdd;
    if (isMainData && mainOdd) begin
      strobe.commit    = 1'b1;
      strobe.commitSrc = 1'b0;
      if (mainPtr < MAIN_W'(FINE_N)) begin
        strobe.seg  = SEG_FINE;
        strobe.slot = SLOT_W'(mainPtr) + SLOT_W'(1);
      end else begin
        strobe.seg  = SEG_COARSE;
        strobe.slot = SLOT_W'(mainPtr - MAIN_W'(FINE_N));
      end
    end
    if (isSfData && sfOdd && sfInRange) begin
      strobe.commit    = 1'b1;
      strobe.commitSrc = 1'b1;
      strobe.seg       = SEG_SUPERFINE;
      strobe.slot      = SLOT_W'(sfPtr);
    end
    strobe.maxLoad[0] = wrEn && (wrAddr == REG_MAX_R);
    strobe.maxLoad[1] = wrEn && (wrAddr == REG_MAX_G);
    strobe.maxLoad[2] = wrEn && (wrAddr == REG_MAX_B);
  end

endmodule

// File: rtl/gamma_port_dp.sv
module gamma_port_dp
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [USED_W-1:0] wrBits,
  input  strobe_t           strobe,
  output logic              lutWrEn,
  output logic [1:0]        lutSeg,
  output logic [SLOT_W-1:0] lutSlot,
  output logic [CH_W-1:0]   lutRed,
  output logic [CH_W-1:0]   lutGreen,
  output logic [CH_W-1:0]   lutBlue,
  output logic [CH_W-1:0]   maxRed,
  output logic [CH_W-1:0]   maxGreen,
  output logic [CH_W-1:0]   maxBlue
);

  localparam int HOLD_W = N_CH * HI_W;

  // one held first word per port
  for (genvar g = 0; g < N_PORT; g++) begin : gHold
    logic [HOLD_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 q <= '0;
      else if (strobe.holdLoad[g]) q <= {wrBits[R_HI_LSB +: HI_W],
                                         wrBits[G_HI_LSB +: HI_W],
                                         wrBits[B_HI_LSB +: HI_W]};
    end
  end

  logic [HOLD_W-1:0] heldHi;
  assign heldHi = strobe.commitSrc ? gHold[1].q : gHold[0].q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lutWrEn  <= 1'b0;
      lutSeg   <= '0;
      lutSlot  <= '0;
      lutRed   <= '0;
      lutGreen <= '0;
      lutBlue  <= '0;
    end else begin
      lutWrEn <= strobe.commit;
      if (strobe.commit) begin
        lutSeg   <= strobe.seg;
        lutSlot  <= strobe.slot;
        lutRed   <= {heldHi[2*HI_W +: HI_W], wrBits[R_LO_LSB +: LO_W]};
        lutGreen <= {heldHi[HI_W +: HI_W],   wrBits[G_LO_LSB +: LO_W]};
        lutBlue  <= {heldHi[0 +: HI_W],      wrBits[B_LO_LSB +: LO_W]};
      end
    end
  end

  // end-point registers, one per channel
  for (genvar c = 0; c < N_CH; c++) begin : gMax
    logic [CH_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                q <= '0;
      else if (strobe.maxLoad[c]) q <= wrBits[CH_W-1:0];
    end
  end

  assign maxRed   = gMax[0].q;
  assign maxGreen = gMax[1].q;
  assign maxBlue  = gMax[2].q;

endmodule

// File: rtl/gamma_lut_port.sv
module gamma_lut_port
  import gamma_lut_pkg::*;
#(
  parameter int FINE_N   = 256,
  parameter int COARSE_N = 256,
  parameter int SF_N     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic              lutWrEn,
  output logic [1:0]        lutSeg,
  output logic [SLOT_W-1:0] lutSlot,
  output logic [CH_W-1:0]   lutRed,
  output logic [CH_W-1:0]   lutGreen,
  output logic [CH_W-1:0]   lutBlue,
  output logic [CH_W-1:0]   maxRed,
  output logic [CH_W-1:0]   maxGreen,
  output logic [CH_W-1:0]   maxBlue
);

  localparam int MAIN_W = $clog2(FINE_N + COARSE_N);
  localparam int SF_W   = $clog2(SF_N + 1);

  strobe_t strobe;
  logic    unusedTopBits;
  assign unusedTopBits = ^wrData[31:USED_W];

  gamma_port_ctrl #(
    .FINE_N  (FINE_N),
    .COARSE_N(COARSE_N),
    .SF_N    (SF_N)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .idxMain(wrData[MAIN_W-1:0]),
    .idxSf  (wrData[SF_W-1:0]),
    .idxAuto(wrData[AUTO_BIT]),
    .strobe (strobe)
  );

  gamma_port_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrBits  (wrData[USED_W-1:0]),
    .strobe  (strobe),
    .lutWrEn (lutWrEn),
    .lutSeg  (lutSeg),
    .lutSlot (lutSlot),
    .lutRed  (lutRed),
    .lutGreen(lutGreen),
    .lutBlue (lutBlue),
    .maxRed  (maxRed),
    .maxGreen(maxGreen),
    .maxBlue (maxBlue)
  );

endmodule

// File: rtl/gamma_lut_port_chk.sv
module gamma_lut_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [2:0]  wrAddr,
  input logic [31:0] wrData,
  input logic        lutWrEn,
  input logic [1:0]  lutSeg,
  input logic [8:0]  lutSlot,
  input logic [15:0] lutRed,
  input logic [15:0] lutGreen,
  input logic [15:0] lutBlue,
  input logic [15:0] maxRed,
  input logic [15:0] maxGreen,
  input logic [15:0] maxBlue
);

  logic unusedChkBits;
  assign unusedChkBits = ^wrData[31:30];

  a_r4_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    lutWrEn |-> $past(wrEn) && ($past(wrAddr) == 3'd1 || $past(wrAddr) == 3'd3));

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lutWrEn |-> $stable({lutSeg, lutSlot, lutRed, lutGreen, lutBlue}));

  a_r3_low_fields: assert property (@(posedge clk) disable iff (!rstN)
    lutWrEn |-> lutRed[5:0] == $past(wrData[29:24]) &&
                lutGreen[5:0] == $past(wrData[19:14]) &&
                lutBlue[5:0] == $past(wrData[9:4]));

  a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn, 2) && $past(wrAddr, 2) == 3'd0 && $past(wrEn) && $past(wrAddr) == 3'd1)
      |-> !lutWrEn);

  a_r7_fine_slot: assert property (@(posedge clk) disable iff (!rstN)
    (lutWrEn && lutSeg == 2'd1) |-> (lutSlot != 9'd0 && lutSlot <= 9'd256));

  a_r7_coarse_slot: assert property (@(posedge clk) disable iff (!rstN)
    (lutWrEn && lutSeg == 2'd2) |-> lutSlot <= 9'd255);

  a_r7_seg_code: assert property (@(posedge clk) disable iff (!rstN)
    lutWrEn |-> lutSeg != 2'd3);

  a_r8_sf_slot: assert property (@(posedge clk) disable iff (!rstN)
    (lutWrEn && lutSeg == 2'd0) |-> lutSlot <= 9'd8);

  a_r10_red_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && $past(wrAddr) == 3'd4) |-> maxRed == $past(wrData[15:0]));

  a_r10_red_hold: assert property (@(posedge clk) disable iff (!rstN)
    !($past(wrEn) && $past(wrAddr) == 3'd4) |-> $stable(maxRed));

  a_r10_green_hold: assert property (@(posedge clk) disable iff (!rstN)
    !($past(wrEn) && $past(wrAddr) == 3'd5) |-> $stable(maxGreen));

  a_r10_blue_hold: assert property (@(posedge clk) disable iff (!rstN)
    !($past(wrEn) && $past(wrAddr) == 3'd6) |-> $stable(maxBlue));

endmodule

bind gamma_lut_port gamma_lut_port_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .lutWrEn(lutWrEn), .lutSeg(lutSeg), .lutSlot(lutSlot),
  .lutRed(lutRed), .lutGreen(lutGreen), .lutBlue(lutBlue),
  .maxRed(maxRed), .maxGreen(maxGreen), .maxBlue(maxBlue)
);

// File: tb/test_gamma_lut_port.sv
`timescale 1ns/1ps
module test_gamma_lut_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        lutWrEn;
  logic [1:0]  lutSeg;
  logic [8:0]  lutSlot;
  logic [15:0] lutRed, lutGreen, lutBlue, maxRed, maxGreen, maxBlue;

  gamma_lut_port i_gamma_lut_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lutWrEn(lutWrEn), .lutSeg(lutSeg), .lutSlot(lutSlot),
    .lutRed(lutRed), .lutGreen(lutGreen), .lutBlue(lutBlue),
    .maxRed(maxRed), .maxGreen(maxGreen), .maxBlue(maxBlue)
  );

  always #5 clk = !clk;

  int    errors = 0;
  int    checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string       tag;
    logic [1:0]  seg;
    logic [8:0]  slot;
    logic [15:0] r, g, b;
    longint      due;
  } exp_t;
  exp_t sb[$];

  // bench model of the pointers, from the requirements
  int         mPtr = 0, sPtr = 0;
  bit         mAuto = 0, sAuto = 0;
  logic [29:0] mHold = '0, sHold = '0;

  function automatic logic [31:0] hiWord(logic [15:0] r, logic [15:0] g, logic [15:0] b);
    return {2'b0, r[15:6], g[15:6], b[15:6]};
  endfunction

  function automatic logic [31:0] loWord(logic [15:0] r, logic [15:0] g, logic [15:0] b);
    return {2'b0, r[5:0], 4'b0, g[5:0], 4'b0, b[5:0], 4'b0};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic mainIdx(int p, bit au);
    mPtr = p; mAuto = au;
    wr(3'd0, {16'b0, au, 6'b0, p[8:0]});
  endtask

  task automatic sfIdx(int p, bit au);
    sPtr = p; sAuto = au;
    wr(3'd2, {16'b0, au, 11'b0, p[3:0]});
  endtask

  task automatic mainHi(logic [15:0] r, logic [15:0] g, logic [15:0] b);
    mHold = {r[15:6], g[15:6], b[15:6]};
    wr(3'd1, hiWord(r, g, b));
  endtask

  task automatic mainLo(string tag, logic [15:0] r, logic [15:0] g, logic [15:0] b);
    exp_t e;
    e.tag  = tag;
    e.seg  = (mPtr < 256) ? 2'd1 : 2'd2;
    e.slot = (mPtr < 256) ? 9'(mPtr + 1) : 9'(mPtr - 256);
    e.r = {mHold[29:20], r[5:0]};
    e.g = {mHold[19:10], g[5:0]};
    e.b = {mHold[9:0], b[5:0]};
    e.due = cyc + 1;
    sb.push_back(e);
    if (mAuto) mPtr = (mPtr + 1) % 512;
    wr(3'd1, loWord(r, g, b));
  endtask

  task automatic mainEntry(string tag, logic [15:0] r, logic [15:0] g, logic [15:0] b);
    mainHi(r, g, b);
    mainLo(tag, r, g, b);
  endtask

  task automatic sfHi(logic [15:0] r, logic [15:0] g, logic [15:0] b);
    sHold = {r[15:6], g[15:6], b[15:6]};
    wr(3'd3, hiWord(r, g, b));
  endtask

  task automatic sfLo(string tag, logic [15:0] r, logic [15:0] g, logic [15:0] b);
    exp_t e;
    if (sPtr <= 8) begin
      e.tag = tag; e.seg = 2'd0; e.slot = 9'(sPtr);
      e.r = {sHold[29:20], r[5:0]};
      e.g = {sHold[19:10], g[5:0]};
      e.b = {sHold[9:0], b[5:0]};
      e.due = cyc + 1;
      sb.push_back(e);
      if (sAuto) sPtr++;
    end
    wr(3'd3, loWord(r, g, b));
  endtask

  // monitor: pops the scoreboard whenever a table write appears
  always @(negedge clk) begin
    if (rstN && lutWrEn) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected write seg %0d slot %0d, expected none", lutSeg, lutSlot);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (lutSeg !== e.seg || lutSlot !== e.slot || lutRed !== e.r ||
            lutGreen !== e.g || lutBlue !== e.b || cyc != e.due) begin
          errors++;
          $display("FAIL %s: actual seg %0d slot %0d rgb %h %h %h cyc %0d, expected seg %0d slot %0d rgb %h %h %h cyc %0d",
                   e.tag, lutSeg, lutSlot, lutRed, lutGreen, lutBlue, cyc,
                   e.seg, e.slot, e.r, e.g, e.b, e.due);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {lutWrEn, lutSeg, lutSlot}, 0);
    check("R1", {lutRed, lutGreen, lutBlue}, 0);
    check("R1", {maxRed, maxGreen, maxBlue}, 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", {lutWrEn, maxRed, maxGreen, maxBlue}, 0);

    // R2 R3 R6 R7: auto-increment fill from the start of the fine segment
    mainIdx(0, 1);
    mainEntry("R2", 16'hFFC0, 16'h0000, 16'h8040);
    mainEntry("R3", 16'h003F, 16'h0015, 16'h002A);
    mainEntry("R6", 16'h1234, 16'hABCD, 16'h5A5A);

    // R4: a lone first word writes nothing
    mainIdx(40, 1);
    mainHi(16'h7777, 16'h8888, 16'h9999);
    check("R4", lutWrEn, 0);
    mainLo("R4", 16'h7777, 16'h8888, 16'h9999);

    // R7: fine/coarse boundary and pointer wrap
    mainIdx(255, 1);
    mainEntry("R7", 16'h0101, 16'h0202, 16'h0303);
    mainEntry("R7", 16'h0404, 16'h0505, 16'h0606);
    mainIdx(511, 1);
    mainEntry("R7", 16'hF00F, 16'h0FF0, 16'hAAAA);
    mainEntry("R7", 16'h5555, 16'hCAFE, 16'hBEEF);

    // R6: no auto-increment keeps the slot
    mainIdx(5, 0);
    mainEntry("R6", 16'h1111, 16'h2222, 16'h3333);
    mainEntry("R6", 16'h4444, 16'h5555, 16'h6666);

    // R5: index write discards a held first word
    mainHi(16'hDEAD, 16'hDEAD, 16'hDEAD);
    mainIdx(10, 1);
    mainEntry("R5", 16'h0ACE, 16'hFACE, 16'h1CE0);

    // R8: superfine fill past its end
    sfIdx(0, 1);
    for (int i = 0; i < 10; i++)
      sfLoPair(i);
    repeat (2) @(posedge clk); #1;
    check("R8", sb.size(), 0);
    sfIdx(8, 1);
    sfHi(16'h2468, 16'h1357, 16'hFEDC);
    sfLo("R8", 16'h2468, 16'h1357, 16'hFEDC);

    // R9: interleaved ports
    mainIdx(20, 1);
    sfIdx(3, 1);
    mainHi(16'hC0DE, 16'h0123, 16'h4567);
    sfHi(16'h89AB, 16'hCDEF, 16'h3210);
    mainLo("R9", 16'hC0DE, 16'h0123, 16'h4567);
    sfLo("R9", 16'h89AB, 16'hCDEF, 16'h3210);

    // R10: end-point registers
    wr(3'd4, 32'hABCD_1234);
    check("R10", {maxRed, maxGreen, maxBlue}, {16'h1234, 16'h0000, 16'h0000});
    wr(3'd5, 32'h0000_FFFF);
    check("R10", {maxRed, maxGreen, maxBlue}, {16'h1234, 16'hFFFF, 16'h0000});
    wr(3'd6, 32'h7FFF_8001);
    check("R10", {maxRed, maxGreen, maxBlue}, {16'h1234, 16'hFFFF, 16'h8001});

    // R11: unused register select
    wr(3'd7, 32'hFFFF_FFFF);
    check("R11", {lutWrEn, maxRed, maxGreen, maxBlue}, {1'b0, 16'h1234, 16'hFFFF, 16'h8001});

    repeat (3) @(posedge clk); #1;
    check("R4", sb.size(), 0);
    finishRun();
  end

  task automatic sfLoPair(int i);
    logic [15:0] v;
    v = 16'(i * 16'h1111 + 16'h0F0F);
    sfHi(v, ~v, v ^ 16'h3C3C);
    sfLo("R8", v, ~v, v ^ 16'h3C3C);
  endtask

endmodule